// File: doc/BRIEF.md
# Bit-Serial Modular Multiplier with Interleaved Reduction

This block multiplies two residues modulo a fixed modulus `Q` by walking the multiplier operand one bit per clock, most significant bit first. At each step the running sum is doubled and the multiplicand is added when the current bit is one. The sum is then brought back below `Q` by subtracting the largest multiple of `Q` (one, two or three times `Q`) that does not exceed it. Because the sum is reduced inside every step, the value left after the last bit is already the final residue. No separate reduction pass follows.

A caller pulses `start` with the multiplicand and the multiplier on the parallel inputs. The multiplier is loaded into a shift register and consumed internally. `done` pulses once when the residue on `product` is final. A combinational modular add/subtract lane sits beside the multiplier for butterfly use. It returns `(a + b) mod Q` or `(a - b) mod Q` with a single conditional correction by `Q`.

Top module: `modq_serial_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: For `mcand` < `Q` and any W-bit `mplier`, the final `product` equals `mcand * mplier mod Q`.
- R3: When `start` is high with `busy` low in clock cycle c, `busy` is high in cycles c+1 to c+W-1. `done` is high in cycle c+W only.
- R4: A `start` pulse while `busy` is high is ignored. Both the running operation's result and its `done` timing are unchanged.
- R5: After `done`, `product` holds its value until the next accepted `start`.
- R6: While `busy` is high, the running partial sum shown on `product` is always below `Q`.
- R7: With `op_sub` = 0 and `op_a`, `op_b` < `Q`, `addsub_out` = `(op_a + op_b) mod Q`.
- R8: With `op_sub` = 1 and `op_a`, `op_b` < `Q`, `addsub_out` = `(op_a - op_b) mod Q`, in the range 0 to `Q`-1.
- R9: `mplier` values of `Q` or more, up to 2^W-1, are accepted unreduced and still give the result of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | W | Multiplicand, already below Q |
| mplier | input | W | Multiplier, any W-bit value |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: product is final |
| product | output | W | Running partial sum, final residue after done |
| op_a | input | W | Add/subtract lane operand a (below Q) |
| op_b | input | W | Add/subtract lane operand b (below Q) |
| op_sub | input | 1 | 1 selects a - b, 0 selects a + b |
| addsub_out | output | W | Modular sum or difference |

## Verification
The partial sum drives `product` directly. A wrong pick of the subtracted multiple therefore shows as a value of `Q` or more on `product` in the same cycle. If it does not show there, it corrupts the final residue W cycles later. An off-by-one in the step counter moves the `done` pulse by a cycle and drops or repeats the last bit, so both the timing and the value checks catch it. A start that leaks into a running operation reloads the operands and shows as a wrong result or a late `done`.

// File: rtl/modq_serial_mul.sv
module modq_serial_mul #(
  parameter int W = 12,
  parameter int Q = 3329
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] product,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         op_sub,
  output logic [W-1:0] addsub_out
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W+1:0] Q1 = (W+2)'(Q);
  localparam logic [W+1:0] Q2 = (W+2)'(2 * Q);
  localparam logic [W+1:0] Q3 = (W+2)'(3 * Q);

  logic [W-1:0]  acc, a_reg, b_sh;
  logic [CW-1:0] cnt;
  logic [W+1:0]  raw, red;
  logic          take;

  assign busy    = (cnt != '0);
  assign take    = start && !busy;
  assign product = acc;

  always_comb begin
    if (take)
      raw = (W+2)'(mplier[W-1] ? mcand : '0);
    else
      raw = {1'b0, acc, 1'b0} + (W+2)'(b_sh[W-1] ? a_reg : '0);
    if (raw >= Q3)      red = raw - Q3;
    else if (raw >= Q2) red = raw - Q2;
    else if (raw >= Q1) red = raw - Q1;
    else                red = raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      a_reg <= '0;
      b_sh  <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (take) begin
      acc   <= red[W-1:0];
      a_reg <= mcand;
      b_sh  <= mplier << 1;
      cnt   <= CW'(W - 1);
      done  <= (W == 1);
    end else if (busy) begin
      acc   <= red[W-1:0];
      b_sh  <= b_sh << 1;
      cnt   <= cnt - 1'b1;
      done  <= (cnt == CW'(1));
    end else begin
      done  <= 1'b0;
    end
  end

  logic [W:0] sum_w, dif_w;
  assign sum_w = {1'b0, op_a} + {1'b0, op_b};
  assign dif_w = {1'b0, op_a} - {1'b0, op_b};
  assign addsub_out = op_sub ? (dif_w[W] ? W'(dif_w + (W+1)'(Q)) : dif_w[W-1:0])
                             : (sum_w >= (W+1)'(Q) ? W'(sum_w - (W+1)'(Q)) : sum_w[W-1:0]);

  // R6
  partial_below_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (product < W'(Q)));

  // R2
  result_below_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product < W'(Q)));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cnt == $past(cnt) - 1'b1));

  // R5
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  // R7
  addsub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a < W'(Q) && op_b < W'(Q)) |-> (addsub_out < W'(Q)));
endmodule

// File: tb/modq_serial_mul_tb.sv
module modq_serial_mul_tb_top;
  localparam int W = 12;
  localparam int Q = 3329;
  localparam time PERIOD = 10ns;

  logic clk = 0, rst_n = 0, start = 0, op_sub = 0;
  logic [W-1:0] mcand = 0, mplier = 0, op_a = 0, op_b = 0;
  logic busy, done;
  logic [W-1:0] product, addsub_out;
  int checks = 0, fails = 0;

  modq_serial_mul #(.W(W), .Q(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product),
    .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .addsub_out(addsub_out));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_mul(input int a, input int b, input string tag, input bit poke);
    int exp = (a * b) % Q;
    bit timing_ok = 1, range_ok = 1;
    int done_at = -1;
    @(negedge clk);
    mcand = W'(a); mplier = W'(b); start = 1;
    for (int i = 1; i <= W; i++) begin
      @(negedge clk);
      start = 0;
      if (poke && i == 3) begin
        start = 1; mcand = W'(7); mplier = W'(4095);
      end else if (poke && i == 4) begin
        start = 0;
      end
      if (done) done_at = i;
      if (done != (i == W)) timing_ok = 0;
      if (i < W && !busy) timing_ok = 0;
      if (product >= W'(Q)) range_ok = 0;
    end
    check(timing_ok, {tag, " R3 done/busy timing, cycle of done"}, done_at, W);
    check(range_ok, {tag, " R6 partial sum below Q"}, int'(product), Q - 1);
    check(product == W'(exp), {tag, " R2 product"}, int'(product), exp);
    if (poke) check(product == W'(exp), {tag, " R4 start while busy ignored"}, int'(product), exp);
    @(negedge clk); @(negedge clk);
    check(product == W'(exp) && !busy && !done, {tag, " R5 product held"}, int'(product), exp);
  endtask

  task automatic test_reset();
    check(!busy && !done && product == 0, "R1 reset state", int'(product), 0);
  endtask

  task automatic test_addsub(input int a, input int b);
    int es = (a + b) % Q;
    int ed = (a - b + Q) % Q;
    op_a = W'(a); op_b = W'(b); op_sub = 0;
    #1;
    check(addsub_out == W'(es), "R7 modular add", int'(addsub_out), es);
    op_sub = 1;
    #1;
    check(addsub_out == W'(ed), "R8 modular subtract", int'(addsub_out), ed);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 3ns);
    test_reset();
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    test_reset();
    run_mul(0, 1234, "zero mcand", 0);
    run_mul(1, 1, "unit", 0);
    run_mul(3328, 3328, "max residues", 0);
    run_mul(1234, 2345, "mid values", 0);
    run_mul(2048, 2048, "power of two", 0);
    run_mul(3328, 4095, "R9 unreduced mplier all ones", 0);
    run_mul(17, 3329, "R9 mplier equal Q", 0);
    run_mul(999, 3000, "busy poke", 1);
    test_addsub(0, 0);
    test_addsub(3328, 3328);
    test_addsub(3328, 1);
    test_addsub(5, 9);
    test_addsub(1000, 1000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule